// File: doc/BRIEF.md
# Programmable Chip-Select and Wait Generator

This block turns the address of each bus cycle into memory chip-select outputs for three programmable regions of a 1 MB space. The upper region always ends at the last address, FFFFFh. The lower region always starts at 00000h. The midrange region sits at a programmable base and is split into four equal sub-selects. A cycle's source does not matter: a cycle started by the processor and a cycle started by the DMA engine are decoded the same way.

Each region has its own count of internal wait states and its own flag that decides whether the external ready input must also be seen. The block latches address bits 2:1 at the start of every cycle. Software configures it through a small port of 16-bit registers.

A bus master starts a cycle by pulsing `cyc_start` with the address on `cyc_addr`. The block then drives one select, or none, for the length of the cycle. It raises `bus_rdy` in the last cycle of the bus cycle.

Top module: `chipsel_wait_unit`

## Requirements
- R1: After reset, every select and `bus_rdy` are low and `lat_a` is 0. The upper region is enabled with size code 0 (1 KB), 3 wait states and external ready required. The lower and midrange regions are disabled.
- R2: Configuration registers are written when `cfg_wr` is high. `cfg_sel` 0 is the upper region, 1 the lower region, 2 the midrange base and 3 the midrange region.
- R3: A region config word uses `cfg_wdata` as follows: [3:0] is the size code, with size = 1 KB << code. [5:4] is the wait count. [6] set means external ready is ignored. [7] set enables the region. The midrange base register takes address bits 19:10 from `cfg_wdata[15:6]`.
- R4: `sel_upper` is asserted for a cycle whose address is at or above 2^20 minus the upper size.
- R5: `sel_lower` is asserted for a cycle whose address is below the lower size.
- R6: The midrange region covers the size-aligned block that contains the base. Within that block, `sel_mid[q]` is asserted, where q is the address quarter (0 is the lowest quarter).
- R7: When regions overlap, exactly one select is asserted. The upper region wins over the lower region, and the lower region wins over the midrange region.
- R8: A cycle that hits no enabled region asserts no select. For such a cycle, `bus_rdy` follows `ext_rdy` with no internal waits.
- R9: With external ready ignored and a wait count of N, `bus_rdy` is high in the (N+1)th cycle after the start edge. The cycle ends at the following edge.
- R10: With external ready required, `bus_rdy` is high only when the wait count has expired and `ext_rdy` is high.
- R11: The select rises at the edge that samples `cyc_start` and stays unchanged until the edge after `bus_rdy`, where it falls.
- R12: `lat_a` takes `cyc_addr[2:1]` at each accepted start and holds that value until the next accepted start.
- R13: A `cyc_start` that arrives while a cycle is in progress is ignored.
- R14: A size code above 8 behaves as code 8 (256 KB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cyc_start | input | 1 | Start of a bus cycle; address valid |
| cyc_addr | input | 20 | Bus cycle address |
| ext_rdy | input | 1 | External ready |
| sel_upper | output | 1 | Upper region select |
| sel_lower | output | 1 | Lower region select |
| sel_mid | output | 4 | Midrange sub-selects |
| bus_rdy | output | 1 | Cycle may end this clock |
| lat_a | output | 2 | Latched address bits 2:1 |

## Verification
Addresses are placed on both sides of every region edge to detect off-by-one errors in size decoding. Midrange addresses step through each quarter, and an unaligned base shows that the base is aligned down to the region size. Overlapping setups and an oversized size code test the select priority and the size clamp. Ready patterns cover:
- ready held high from the start, which isolates the internal wait count;
- ready raised late, which shows the count and external ready combine;
- ready with the ignore flag set, which shows external ready is not needed.

Extra start pulses sent in the middle of a cycle show that they cannot disturb the cycle in progress.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam int ADDR_W   = 20;
  localparam int MIN_SH   = 10;
  localparam int MAX_CODE = 8;
  localparam int BASE_W   = ADDR_W - MIN_SH;
  localparam int NUM_MID  = 4;
  localparam int NUM_SEL  = 2 + NUM_MID;
  localparam int WAIT_W   = 2;

  typedef struct packed {
    logic              en;
    logic              ign;
    logic [WAIT_W-1:0] waits;
    logic [3:0]        code;
  } region_cfg_t;

  function automatic int unsigned eff_shift(input logic [3:0] code);
    return MIN_SH + ((int'(code) > MAX_CODE) ? MAX_CODE : int'(code));
  endfunction

  function automatic logic top_hit(input logic [ADDR_W-1:0] a, input logic [3:0] code);
    return (((~a) >> eff_shift(code)) == '0);
  endfunction

  function automatic logic bottom_hit(input logic [ADDR_W-1:0] a, input logic [3:0] code);
    return ((a >> eff_shift(code)) == '0);
  endfunction

  function automatic logic block_hit(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [3:0] code);
    return ((a >> eff_shift(code)) == (base >> eff_shift(code)));
  endfunction

  function automatic logic [1:0] quarter(input logic [ADDR_W-1:0] a, input logic [3:0] code);
    logic [ADDR_W-1:0] t;
    t = a >> (eff_shift(code) - 2);
    return t[1:0];
  endfunction
endpackage

// File: rtl/csw_regfile.sv
module csw_regfile
  import csw_pkg::*;
#(
  parameter logic [7:0] UPPER_RST = 8'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [15:0]       wdata,
  output region_cfg_t       up_cfg,
  output region_cfg_t       lo_cfg,
  output region_cfg_t       mid_cfg,
  output logic [BASE_W-1:0] mid_base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cfg   <= region_cfg_t'(UPPER_RST);
      lo_cfg   <= '0;
      mid_cfg  <= '0;
      mid_base <= '0;
    end else if (wr) begin
      case (sel)
        2'd0: up_cfg   <= region_cfg_t'(wdata[7:0]);
        2'd1: lo_cfg   <= region_cfg_t'(wdata[7:0]);
        2'd2: mid_base <= wdata[15:16-BASE_W];
        default: mid_cfg <= region_cfg_t'(wdata[7:0]);
      endcase
    end
  end
endmodule

// File: rtl/csw_decode.sv
module csw_decode
  import csw_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  region_cfg_t        up_cfg,
  input  region_cfg_t        lo_cfg,
  input  region_cfg_t        mid_cfg,
  input  logic [BASE_W-1:0]  mid_base,
  output logic [NUM_SEL-1:0] hit_vec,
  output logic [WAIT_W-1:0]  waits,
  output logic               ign
);
  logic [ADDR_W-1:0] base_addr;
  logic up_hit, lo_hit, mid_hit;

  assign base_addr = {mid_base, {MIN_SH{1'b0}}};
  assign up_hit    = up_cfg.en  && top_hit(addr, up_cfg.code);
  assign lo_hit    = lo_cfg.en  && bottom_hit(addr, lo_cfg.code);
  assign mid_hit   = mid_cfg.en && block_hit(addr, base_addr, mid_cfg.code);

  always_comb begin
    hit_vec = '0;
    waits   = '0;
    ign     = 1'b0;
    if (up_hit) begin
      hit_vec[0] = 1'b1;
      waits      = up_cfg.waits;
      ign        = up_cfg.ign;
    end else if (lo_hit) begin
      hit_vec[1] = 1'b1;
      waits      = lo_cfg.waits;
      ign        = lo_cfg.ign;
    end else if (mid_hit) begin
      hit_vec[2 + int'(quarter(addr, mid_cfg.code))] = 1'b1;
      waits      = mid_cfg.waits;
      ign        = mid_cfg.ign;
    end
  end
endmodule

// File: rtl/csw_cycle.sv
module csw_cycle
  import csw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               ext_rdy,
  input  logic [NUM_SEL-1:0] dec_sel,
  input  logic [WAIT_W-1:0]  dec_waits,
  input  logic               dec_ign,
  input  logic [1:0]         a21,
  output logic [NUM_SEL-1:0] sel_q,
  output logic               busy,
  output logic               bus_rdy,
  output logic [1:0]         lat_a
);
  logic [WAIT_W-1:0] cnt;
  logic              ign_q;
  logic              accept;
  logic              cnt_done;

  assign accept   = start && !busy;
  assign cnt_done = (cnt == '0);
  assign bus_rdy  = busy && cnt_done && (ign_q || ext_rdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sel_q <= '0;
      cnt   <= '0;
      ign_q <= 1'b0;
      lat_a <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      sel_q <= dec_sel;
      cnt   <= dec_waits;
      ign_q <= dec_ign;
      lat_a <= a21;
    end else if (bus_rdy) begin
      busy  <= 1'b0;
      sel_q <= '0;
    end else if (busy && !cnt_done) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R7
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel_q));
  // R11
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_rdy |=> $stable(sel_q));
  // R11
  sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy |=> !busy && (sel_q == '0));
  // R12
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lat_a));
  // R10
  ext_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy && !ext_rdy |-> ign_q);
  // R13
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !bus_rdy |=> busy);
endmodule

// File: rtl/chipsel_wait_unit.sv
module chipsel_wait_unit
  import csw_pkg::*;
#(
  parameter logic [7:0] UPPER_RST = 8'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic              cyc_start,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              ext_rdy,
  output logic              sel_upper,
  output logic              sel_lower,
  output logic [NUM_MID-1:0] sel_mid,
  output logic              bus_rdy,
  output logic [1:0]        lat_a
);
  region_cfg_t        up_cfg, lo_cfg, mid_cfg;
  logic [BASE_W-1:0]  mid_base;
  logic [NUM_SEL-1:0] dec_sel, sel_q;
  logic [WAIT_W-1:0]  dec_waits;
  logic               dec_ign;
  logic               busy;

  csw_regfile #(.UPPER_RST(UPPER_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .up_cfg(up_cfg), .lo_cfg(lo_cfg), .mid_cfg(mid_cfg), .mid_base(mid_base)
  );

  csw_decode u_dec (
    .addr(cyc_addr), .up_cfg(up_cfg), .lo_cfg(lo_cfg), .mid_cfg(mid_cfg),
    .mid_base(mid_base), .hit_vec(dec_sel), .waits(dec_waits), .ign(dec_ign)
  );

  csw_cycle u_cyc (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .ext_rdy(ext_rdy),
    .dec_sel(dec_sel), .dec_waits(dec_waits), .dec_ign(dec_ign),
    .a21(cyc_addr[2:1]), .sel_q(sel_q), .busy(busy), .bus_rdy(bus_rdy),
    .lat_a(lat_a)
  );

  assign sel_upper = sel_q[0];
  assign sel_lower = sel_q[1];
  assign sel_mid   = sel_q[NUM_SEL-1:2];

  // R8
  miss_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (sel_q == '0) |-> (bus_rdy == ext_rdy));
  // R13
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && !busy |=> busy);
endmodule

// File: tb/tb_chipsel_wait_unit.sv
module tb_chipsel_wait_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        cyc_start = 1'b0;
  logic [19:0] cyc_addr = '0;
  logic        ext_rdy = 1'b0;
  logic        sel_upper, sel_lower, bus_rdy;
  logic [3:0]  sel_mid;
  logic [1:0]  lat_a;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  chipsel_wait_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
    .ext_rdy(ext_rdy), .sel_upper(sel_upper), .sel_lower(sel_lower),
    .sel_mid(sel_mid), .bus_rdy(bus_rdy), .lat_a(lat_a)
  );

  // reference model: region 0 upper, 1 lower, 2 mid
  int m_en[3], m_ign[3], m_wait[3], m_code[3];
  int m_base;
  bit m_busy;
  int m_idx, m_cnt, m_ig, m_lat;

  function automatic int region_size(int code);
    return 1024 << ((code > 8) ? 8 : code);
  endfunction

  function automatic int ref_pick(int a);
    int sz, b;
    if (m_en[0] != 0 && a >= (1 << 20) - region_size(m_code[0])) return 1;
    if (m_en[1] != 0 && a < region_size(m_code[1])) return 2;
    sz = region_size(m_code[2]);
    b  = (m_base / sz) * sz;
    if (m_en[2] != 0 && a >= b && a < b + sz) return 3 + (a - b) / (sz / 4);
    return 0;
  endfunction

  function automatic bit ref_rdy();
    return m_busy && m_cnt == 0 && (m_ig != 0 || ext_rdy);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '{1, 0, 0}; m_ign = '{0, 0, 0}; m_wait = '{3, 0, 0}; m_code = '{0, 0, 0};
      m_base = 0; m_busy = 0; m_idx = 0; m_cnt = 0; m_ig = 0; m_lat = 0;
    end else begin
      bit r;
      r = ref_rdy();
      if (!m_busy && cyc_start) begin
        int p;
        p = ref_pick(int'(cyc_addr));
        m_busy = 1; m_idx = p; m_lat = int'(cyc_addr[2:1]);
        if (p == 0) begin m_cnt = 0; m_ig = 0; end
        else begin
          int g;
          g = (p >= 3) ? 2 : p - 1;
          m_cnt = m_wait[g]; m_ig = m_ign[g];
        end
      end else if (r) begin
        m_busy = 0; m_idx = 0;
      end else if (m_busy && m_cnt > 0) m_cnt--;
      if (cfg_wr) begin
        if (cfg_sel == 2) m_base = int'(cfg_wdata[15:6]) * 1024;
        else begin
          int g;
          g = (cfg_sel == 3) ? 2 : int'(cfg_sel);
          m_code[g] = cfg_wdata & 15; m_wait[g] = (cfg_wdata >> 4) & 3;
          m_ign[g] = (cfg_wdata >> 6) & 1; m_en[g] = (cfg_wdata >> 7) & 1;
        end
      end
    end
  end

  // per-cycle compare, away from the edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      bit eu, el, er;
      logic [3:0] em;
      eu = (m_idx == 1); el = (m_idx == 2);
      em = (m_idx >= 3) ? (4'b1 << (m_idx - 3)) : 4'b0;
      er = ref_rdy();
      total++;
      if (sel_upper !== eu || sel_lower !== el || sel_mid !== em ||
          bus_rdy !== er || lat_a !== 2'(m_lat)) begin
        bad++;
        $display("FAIL %s: got u=%b l=%b m=%b r=%b a=%b exp u=%b l=%b m=%b r=%b a=%b",
                 tag, sel_upper, sel_lower, sel_mid, bus_rdy, lat_a,
                 eu, el, em, er, 2'(m_lat));
      end
    end
  end

  task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  // one bus cycle: ext_rdy goes high rdly cycles after start; poke = stray start
  task automatic bus_cycle(input logic [19:0] a, input int rdly, input bit poke);
    int k;
    @(negedge clk); cyc_start = 1; cyc_addr = a; ext_rdy = (rdly == 0);
    @(negedge clk); cyc_start = 0;
    k = 1;
    while (m_busy && k < 60) begin
      if (poke && k == 1) begin cyc_start = 1; cyc_addr = ~a; end
      ext_rdy = (k >= rdly);
      @(negedge clk); cyc_start = 0;
      k++;
    end
    ext_rdy = 0;
  endtask

  task automatic direct(input string t, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b exp %b", t, got, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R1 reset state
    direct("R1 sel", |{sel_upper, sel_lower, sel_mid}, 1'b0);
    direct("R1 rdy", bus_rdy, 1'b0);
    direct("R1 lat", |lat_a, 1'b0);
    // R1 default upper covers reset fetch, R10 waits plus late ready
    tag = "R10";
    @(negedge clk); cyc_start = 1; cyc_addr = 20'hFFFF0;
    @(negedge clk); cyc_start = 0; #2;
    direct("R1 upper default", sel_upper, 1'b1);
    repeat (6) @(negedge clk);
    ext_rdy = 1; @(negedge clk); ext_rdy = 0;
    repeat (2) @(negedge clk);
    bus_cycle(20'hFFC00, 0, 0);
    bus_cycle(20'hFFBFF, 2, 0);        // R8 miss
    // R2 R3 R4 R9: upper 4KB, 1 wait, ignore ready
    tag = "R4";
    wr_reg(2'd0, 16'h00D2);
    bus_cycle(20'hFF000, 9, 0);
    bus_cycle(20'hFFFFE, 9, 0);
    tag = "R8";
    bus_cycle(20'hFEFFF, 3, 0);
    // R5 lower 2KB, 0 waits, ignore ready
    tag = "R5";
    wr_reg(2'd1, 16'h00C1);
    bus_cycle(20'h007FF, 5, 0);
    bus_cycle(20'h00000, 5, 0);
    tag = "R8";
    bus_cycle(20'h00800, 1, 0);
    // R6 mid 8KB at 40000h, 2 waits, ignore ready; R12 lat_a values
    tag = "R6";
    wr_reg(2'd2, 16'h4000);
    wr_reg(2'd3, 16'h00E3);
    bus_cycle(20'h40002, 9, 0);
    bus_cycle(20'h40804, 9, 0);
    bus_cycle(20'h41006, 9, 0);
    bus_cycle(20'h41FFF, 9, 0);
    tag = "R8";
    bus_cycle(20'h42000, 0, 0);
    bus_cycle(20'h3FFFF, 0, 0);
    // R6 unaligned base aligns down to region size
    tag = "R6";
    wr_reg(2'd2, 16'h4100);
    bus_cycle(20'h40000, 9, 0);
    bus_cycle(20'h41C00, 9, 0);
    // R10 mid requiring ext ready, 2 waits
    tag = "R10";
    wr_reg(2'd3, 16'h00A3);
    bus_cycle(20'h40100, 0, 0);
    bus_cycle(20'h40100, 1, 0);
    bus_cycle(20'h40100, 5, 0);
    // R13 stray start while busy
    tag = "R13";
    bus_cycle(20'h40A00, 4, 1);
    bus_cycle(20'hFF002, 0, 1);
    // R7 priority, R14 clamp
    tag = "R7";
    wr_reg(2'd1, 16'h00C8);            // lower 256KB
    wr_reg(2'd2, 16'h0000);            // mid at 0, overlaps lower
    bus_cycle(20'h00100, 0, 0);
    tag = "R14";
    wr_reg(2'd0, 16'h00CF);            // upper code 15 -> 256KB
    bus_cycle(20'hC0000, 0, 0);
    bus_cycle(20'hBFFFF, 0, 0);
    tag = "R7";
    wr_reg(2'd2, 16'hC000);            // mid at C0000h, overlaps upper
    bus_cycle(20'hC0400, 0, 0);
    wr_reg(2'd2, 16'h8000);            // mid at 80000h alone
    bus_cycle(20'h81000, 3, 0);
    // R8 disabled region gives no select
    tag = "R8";
    wr_reg(2'd3, 16'h0063);
    bus_cycle(20'h81000, 2, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule